// File: doc/BRIEF.md
# Command Slot Issue Scheduler

This block is the front end of a per-port command engine. Software sets bits in a command-issue vector, one bit per command slot. The block picks the next issued slot and hands it to a single command executor over a valid/ready handshake. When that command finishes, the block clears the slot's bit. It also holds the port control word, which has start and FIS-receive enables and a running indicator for each.

Two inputs from the executor can hold dispatch back: a busy flag and a data-request flag. The executor ends each command with a completion pulse. If the executor is still busy or requesting data at that pulse, the command has gone asynchronous. The block keeps the slot as the outstanding slot and clears its bit only when both flags drop.

The block has three further duties. It issues a one-shot request for the initial device-to-host status FIS. It starts a port reset when the link-control detect field is written from 1 to 0. On that reset it loads the device signature.

Top module: `cmd_slot_sched`

## Requirements
- R1: After reset, `issue_vec`, `ctl_word` and `sig_out` are zero, and `disp_valid`, `init_fis_req` and `port_reset` are low.
- R2: A write with `reg_wr_sel`=0 loads the control word from the written data. `ctl_word`[0] is start, taken from data bit 0. `ctl_word`[1] is FIS-receive enable, taken from data bit 1. `ctl_word`[2] is FIS running and equals the new data bit 1. `ctl_word`[3] is list running and equals the new data bit 0. Written data bits 2 and 3 are ignored.
- R3: The first control write with data bit 1 set after reset or a port reset raises `init_fis_req` for exactly one cycle. Later such writes raise it again only after another port reset.
- R4: A write with `reg_wr_sel`=1 ORs the written data into `issue_vec`. It never clears a bit.
- R5: While start is set, the lowest-numbered issued slot is offered on `disp_slot` with `disp_valid` high. The block offers one slot at a time and holds the slot stable until `disp_ready` is seen.
- R6: No new slot is offered while `dev_busy` or `dev_drq` is high. The issued bits stay set until a later retry.
- R7: If `dev_busy` or `dev_drq` is high at `exec_done`, the slot stays issued and nothing more is dispatched. When both flags drop, the slot's bit is cleared and scanning resumes.
- R8: A write with `reg_wr_sel`=2 whose data bits [3:0] go to 0 while the previously written detect value was 1 pulses `port_reset` for one cycle and clears `issue_vec`. A change from any other value to 0 does nothing.
- R9: Clearing start blocks any new dispatch. A slot already handed over still completes and has its bit cleared.
- R10: On a port reset `sig_out` becomes 0 when `dev_present` is low. It becomes 0xEB140101 when the device is optical. It becomes 0x00000101 for any other device.
- R11: A slot whose `exec_done` comes with both `dev_busy` and `dev_drq` low has its issue bit cleared on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Target: 0 control, 1 command issue, 2 link control |
| reg_wr_data | input | 32 | Write data |
| dev_busy | input | 1 | Executor busy |
| dev_drq | input | 1 | Executor data request |
| dev_present | input | 1 | A device is attached |
| dev_optical | input | 1 | Attached device is an optical packet device |
| exec_done | input | 1 | Executor finished the handed-over command |
| disp_ready | input | 1 | Executor accepts a dispatch |
| disp_valid | output | 1 | Slot offered for dispatch |
| disp_slot | output | 5 | Slot number offered |
| issue_vec | output | 32 | Current command-issue vector |
| ctl_word | output | 4 | {list run, FIS run, FIS enable, start} |
| init_fis_req | output | 1 | One-cycle initial status FIS request |
| port_reset | output | 1 | One-cycle port reset pulse |
| sig_out | output | 32 | Device signature |

## Verification
The scan is driven with several issue masks: a single low bit, a single top bit, a contiguous run, sparse bits at both ends, and a pair in the middle. Together they show whether the block picks the lowest slot first, keeps ascending order, and dispatches each issued bit exactly once. Directed cases hold busy before issue to separate deferral from dispatch. One case raises busy at completion to separate the asynchronous path from synchronous clearing. Another drops start between handoff and completion. The detect-field writes use the values 1 and 2 before 0, which separates the real reset trigger from a plain write of 0.

// File: rtl/cmd_slot_sched.sv
module cmd_slot_sched #(
  parameter int SLOTS = 32,
  parameter int DW = 32,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [1:0]       reg_wr_sel,
  input  logic [DW-1:0]    reg_wr_data,
  input  logic             dev_busy,
  input  logic             dev_drq,
  input  logic             dev_present,
  input  logic             dev_optical,
  input  logic             exec_done,
  input  logic             disp_ready,
  output logic             disp_valid,
  output logic [SW-1:0]    disp_slot,
  output logic [SLOTS-1:0] issue_vec,
  output logic [3:0]       ctl_word,
  output logic             init_fis_req,
  output logic             port_reset,
  output logic [31:0]      sig_out
);
  localparam logic [31:0] SIG_OPTICAL = 32'hEB14_0101;
  localparam logic [31:0] SIG_DISK    = 32'h0000_0101;

  typedef enum logic [1:0] {S_IDLE, S_DISP, S_WAIT, S_ASYNC} st_t;

  st_t             st_q;
  logic [SLOTS-1:0] issue_q, issue_set, clr_mask;
  logic [SW-1:0]   slot_q, pick;
  logic            found;
  logic            start_q, fisen_q, lrun_q, frun_q;
  logic [3:0]      det_q;
  logic            init_sent_q, init_req_q, prst_q;
  logic [31:0]     sig_q;

  wire wr_ctl   = reg_wr_en && reg_wr_sel == 2'd0;
  wire wr_iss   = reg_wr_en && reg_wr_sel == 2'd1;
  wire wr_lnk   = reg_wr_en && reg_wr_sel == 2'd2;
  wire dev_hold = dev_busy | dev_drq;
  wire prst_hit = wr_lnk && det_q == 4'd1 && reg_wr_data[3:0] == 4'd0;
  wire [31:0] sig_next = !dev_present ? 32'd0 : (dev_optical ? SIG_OPTICAL : SIG_DISK);

  assign issue_set = wr_iss ? reg_wr_data[SLOTS-1:0] : '0;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (issue_q[i]) begin
        found = 1'b1;
        pick  = SW'(i);
      end
    end
  end

  always_comb begin
    clr_mask = '0;
    if ((st_q == S_WAIT && exec_done && !dev_hold) || (st_q == S_ASYNC && !dev_hold))
      clr_mask[slot_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= S_IDLE;
      issue_q     <= '0;
      slot_q      <= '0;
      start_q     <= 1'b0;
      fisen_q     <= 1'b0;
      lrun_q      <= 1'b0;
      frun_q      <= 1'b0;
      det_q       <= '0;
      init_sent_q <= 1'b0;
      init_req_q  <= 1'b0;
      prst_q      <= 1'b0;
      sig_q       <= '0;
    end else begin
      prst_q     <= prst_hit;
      init_req_q <= 1'b0;
      if (wr_lnk) det_q <= reg_wr_data[3:0];
      if (wr_ctl) begin
        start_q <= reg_wr_data[0];
        fisen_q <= reg_wr_data[1];
        lrun_q  <= reg_wr_data[0];
        frun_q  <= reg_wr_data[1];
        if (reg_wr_data[1] && !init_sent_q) begin
          init_req_q  <= 1'b1;
          init_sent_q <= 1'b1;
        end
      end
      if (prst_hit) begin
        issue_q     <= '0;
        st_q        <= S_IDLE;
        init_sent_q <= 1'b0;
        sig_q       <= sig_next;
      end else begin
        issue_q <= (issue_q | issue_set) & ~clr_mask;
        unique case (st_q)
          S_IDLE:  if (start_q && found && !dev_hold) begin
                     slot_q <= pick;
                     st_q   <= S_DISP;
                   end
          S_DISP:  if (disp_ready) st_q <= S_WAIT;
          S_WAIT:  if (exec_done) st_q <= dev_hold ? S_ASYNC : S_IDLE;
          S_ASYNC: if (!dev_hold) st_q <= S_IDLE;
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign disp_valid   = st_q == S_DISP;
  assign disp_slot    = slot_q;
  assign issue_vec    = issue_q;
  assign ctl_word     = {lrun_q, frun_q, fisen_q, start_q};
  assign init_fis_req = init_req_q;
  assign port_reset   = prst_q;
  assign sig_out      = sig_q;
endmodule

// File: rtl/cmd_slot_sched_chk.sv
module cmd_slot_sched_chk #(
  parameter int SLOTS = 32,
  localparam int SW = $clog2(SLOTS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dev_busy,
  input logic             dev_drq,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic [SW-1:0]    disp_slot,
  input logic [SLOTS-1:0] issue_vec,
  input logic             init_fis_req,
  input logic             port_reset
);
  // R5
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid && !disp_ready && !port_reset |=> (disp_valid || port_reset) && (port_reset || $stable(disp_slot)));

  // R5
  offer_issued_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> issue_vec[disp_slot]);

  // R6
  no_busy_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_valid) |-> !$past(dev_busy) && !$past(dev_drq));

  // R3
  init_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_fis_req |=> !init_fis_req);

  // R8
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_reset |-> issue_vec == '0 && !disp_valid);
endmodule

bind cmd_slot_sched cmd_slot_sched_chk #(.SLOTS(SLOTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .dev_busy(dev_busy), .dev_drq(dev_drq),
  .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_slot(disp_slot),
  .issue_vec(issue_vec), .init_fis_req(init_fis_req), .port_reset(port_reset)
);

// File: tb/cmd_slot_sched_tb_top.sv
`timescale 1ns/1ps
module cmd_slot_sched_tb_top;
  logic clk = 0, rst_n = 0;
  logic reg_wr_en = 0;
  logic [1:0] reg_wr_sel = 0;
  logic [31:0] reg_wr_data = 0;
  logic dev_busy = 0, dev_drq = 0, dev_present = 1, dev_optical = 0;
  logic exec_done = 0, disp_ready = 0;
  logic disp_valid, init_fis_req, port_reset;
  logic [4:0] disp_slot;
  logic [31:0] issue_vec, sig_out;
  logic [3:0] ctl_word;

  int n_chk = 0, n_bad = 0, cyc = 0, init_cnt = 0, prst_cnt = 0;

  always #4 clk = ~clk;

  cmd_slot_sched dut_i (.*);

  always @(negedge clk) begin
    cyc++;
    if (init_fis_req) init_cnt++;
    if (port_reset) prst_cnt++;
  end

  // entries: {mask, first slot, slot count}
  localparam logic [31:0] VEC [5][3] = '{
    '{32'h0000_0001, 32'd0,  32'd1},
    '{32'h8000_0000, 32'd31, 32'd1},
    '{32'h0000_00F0, 32'd4,  32'd4},
    '{32'h8000_0081, 32'd0,  32'd3},
    '{32'h0000_A000, 32'd13, 32'd2}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    reg_wr_en = 1; reg_wr_sel = sel; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic accept(output int slot);
    int w = 0;
    while (!disp_valid && w < 50) begin @(negedge clk); w++; end
    slot = disp_valid ? int'(disp_slot) : -1;
    disp_ready = 1;
    @(negedge clk);
    disp_ready = 0;
  endtask

  task automatic finish_cmd(input logic busy_after);
    exec_done = 1; dev_busy = busy_after;
    @(negedge clk);
    exec_done = 0;
  endtask

  task automatic quiet(input int n, output int seen);
    seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (disp_valid) seen++; end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    while (cyc < 20000) @(negedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected<20000", cyc);
    summary();
  end

  initial begin
    int s, prev, cnt, seen, c0;
    idle(2);
    // R1 reset state
    chk("R1 issue", issue_vec, 0);
    chk("R1 ctl", {28'd0, ctl_word}, 0);
    chk("R1 valid/pulses", {29'd0, disp_valid, init_fis_req, port_reset}, 0);
    chk("R1 sig", sig_out, 0);
    rst_n = 1;
    idle(2);

    // R2 control word
    wr(2'd0, 32'h0000_000D);
    chk("R2 start only", {28'd0, ctl_word}, 32'h9);
    // R3 first FIS enable requests once
    c0 = init_cnt;
    wr(2'd0, 32'h0000_0002);
    chk("R2 fis only", {28'd0, ctl_word}, 32'h6);
    idle(2);
    chk("R3 first pulse", init_cnt - c0, 1);
    wr(2'd0, 32'h0000_0000);
    wr(2'd0, 32'h0000_0002);
    idle(2);
    chk("R3 no repeat", init_cnt - c0, 1);
    wr(2'd0, 0);

    // R4 OR write
    wr(2'd1, 32'h0000_0001);
    wr(2'd1, 32'h0000_0002);
    chk("R4 or", issue_vec, 32'h3);
    wr(2'd1, 32'h0000_0000);
    chk("R4 zero write", issue_vec, 32'h3);

    // R8 / R10 disk signature, clears issue
    dev_present = 1; dev_optical = 0;
    wr(2'd2, 1);
    c0 = prst_cnt;
    wr(2'd2, 0);
    idle(1);
    chk("R8 pulse", prst_cnt - c0, 1);
    chk("R8 cleared", issue_vec, 0);
    chk("R10 disk", sig_out, 32'h0000_0101);
    // R3 again after port reset
    c0 = init_cnt;
    wr(2'd0, 32'h2);
    idle(2);
    chk("R3 after port reset", init_cnt - c0, 1);
    wr(2'd0, 0);
    // R8 non-trigger
    wr(2'd1, 32'h10);
    wr(2'd2, 2);
    c0 = prst_cnt;
    wr(2'd2, 0);
    idle(2);
    chk("R8 2->0 no pulse", prst_cnt - c0, 0);
    chk("R8 issue kept", issue_vec, 32'h10);
    // R10 optical then absent
    dev_optical = 1;
    wr(2'd2, 1); wr(2'd2, 0);
    chk("R10 optical", sig_out, 32'hEB14_0101);
    dev_present = 0;
    wr(2'd2, 1); wr(2'd2, 0);
    chk("R10 none", sig_out, 0);
    dev_present = 1; dev_optical = 0;

    // R5 / R11 scan table
    wr(2'd0, 32'h1);
    for (int k = 0; k < 5; k++) begin
      wr(2'd1, VEC[k][0]);
      accept(s);
      chk("R5 first slot", s, VEC[k][1]);
      finish_cmd(0);
      chk("R11 sync clear", issue_vec & (32'h1 << VEC[k][1]), 0);
      prev = s; cnt = 1;
      while (issue_vec != 0 && cnt < 40) begin
        accept(s);
        chk("R5 ascending", s > prev, 1);
        prev = s;
        finish_cmd(0);
        cnt++;
      end
      chk("R5 count", cnt, VEC[k][2]);
    end

    // R6 busy deferral
    dev_busy = 1;
    wr(2'd1, 32'h4);
    quiet(10, seen);
    chk("R6 no offer busy", seen, 0);
    chk("R6 still issued", issue_vec, 32'h4);
    dev_busy = 0; dev_drq = 1;
    quiet(5, seen);
    chk("R6 no offer drq", seen, 0);
    dev_drq = 0;
    accept(s);
    chk("R6 retry slot", s, 2);
    finish_cmd(0);

    // R7 async completion
    wr(2'd1, 32'h3);
    accept(s);
    chk("R7 first", s, 0);
    finish_cmd(1);
    quiet(6, seen);
    chk("R7 held", seen, 0);
    chk("R7 bit kept", issue_vec, 32'h3);
    dev_busy = 0;
    @(negedge clk);
    chk("R7 cleared on drop", issue_vec, 32'h2);
    accept(s);
    chk("R7 resume", s, 1);
    finish_cmd(0);

    // R9 stop while in flight
    wr(2'd1, 32'h3);
    accept(s);
    wr(2'd0, 32'h0);
    finish_cmd(0);
    chk("R9 in-flight done", issue_vec, 32'h2);
    quiet(8, seen);
    chk("R9 no dispatch", seen, 0);
    wr(2'd0, 32'h1);
    accept(s);
    chk("R9 restart", s, 1);
    finish_cmd(0);
    chk("R9 empty", issue_vec, 0);

    summary();
  end
endmodule